// File: doc/BRIEF.md
# Circular Return-Address Stack

This block holds return addresses for a small processor core. It is a private eight-slot by thirteen-bit store that sits outside both program and data memory. The core asks for a push when it executes a subroutine call or when it takes the interrupt vector. It asks for a pop when it executes any of its three return forms: a plain return, a return that also loads a literal, or a return from interrupt. The block decides nothing on its own: it acts only on these two strobes.

The slot index is kept inside the block, and nothing outside can read it or load it. The store is a ring. A push stores the incoming address in the slot the index names and then moves the index forward. A pop moves the index back and then reads that slot. The index wraps in both directions. When the core nests deeper than eight levels, the oldest address is overwritten without notice. When it returns more times than it called, it gets whatever stale address the wrapped index selects. There is no overflow or underflow indication.

The popped address is registered. It appears on the output after the clock edge that samples the pop strobe, and it holds there until the next pop. Reset clears the index and the output register, but it leaves the stored addresses as they are.

Top module: `ret_stack`

## Requirements
- R1: While `rst` is high at a rising edge, the internal slot index returns to 0 and `pop_addr` returns to 0. After reset, the first push therefore lands in slot 0.
- R2: A push stores `push_addr` in the slot named by the index, then advances the index by one. After slot 7 the index wraps to slot 0.
- R3: A pop moves the index back by one, wrapping from slot 0 to slot 7, and loads that slot into `pop_addr` at the same rising edge. `pop_addr` then holds its value until the next pop.
- R4: Interleaved pushes and pops behave last-in first-out. Each pop returns the most recent pushed address that has not yet been popped, provided no more than eight addresses are outstanding.
- R5: With eight slots, the ninth push in a row overwrites the address from the first push, and the tenth overwrites the second. After nine pushes, eight pops return pushes nine down to two, and a ninth pop returns push nine again.
- R6: A pop with nothing outstanding raises no error. It returns the stale contents of the slot that the wrapped index selects.
- R7: Reset does not clear the stored addresses. After eight pushes and a reset, a push followed by two pops returns the new address and then the address from the eighth push before the reset (slot 7).
- R8: A cycle with neither push nor pop changes nothing. `pop_addr` holds its value, and later pops return the same values they would have returned without the idle cycle.
- R9: Push and pop must never be asserted in the same cycle. The block may assume this and does not define what happens if it occurs.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| push | input | 1 | Store `push_addr` and advance the index (call or interrupt entry) |
| push_addr | input | 13 | Return address to save |
| pop | input | 1 | Step the index back and read that slot (any return form) |
| pop_addr | output | 13 | Registered address from the most recent pop |

## Verification
The assertions assume that push and pop are never high in the same cycle. The index-step and write-landing properties are written only for cycles where at most one strobe is set. The bench chooses a single operation per cycle from one random draw: push, pop or idle. It therefore cannot raise both strobes at once. The random mix favours pushes, so the ring wraps in both directions, while pops still often run past the entries written.

// File: rtl/ret_stack_pkg.sv
package ret_stack_pkg;

    localparam int STK_DEPTH = 8;
    localparam int STK_WIDTH = 13;

    typedef enum logic [1:0] {
        STK_IDLE = 2'd0,
        STK_PUSH = 2'd1,
        STK_POP  = 2'd2
    } stk_op_e;

    // Step a ring index one place in the direction the operation asks for.
    function automatic int ring_step(input int cur, input int depth, input stk_op_e op);
        int nxt;
        nxt = cur;
        if (op == STK_PUSH) begin
            nxt = (cur == depth - 1) ? 0 : cur + 1;
        end else if (op == STK_POP) begin
            nxt = (cur == 0) ? depth - 1 : cur - 1;
        end
        return nxt;
    endfunction

endpackage

// File: rtl/ret_stack_ctrl.sv
module ret_stack_ctrl
    import ret_stack_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    push,
    input  logic    pop,
    output stk_op_e op
);

    always_comb begin
        if (push)      op = STK_PUSH;
        else if (pop)  op = STK_POP;
        else           op = STK_IDLE;
    end

    AST_NO_PUSH_POP: assert property (@(posedge clk) disable iff (rst)
        !(push && pop)); // R9

endmodule

// File: rtl/ret_stack_ptr.sv
module ret_stack_ptr
    import ret_stack_pkg::*;
#(
    parameter int DEPTH = STK_DEPTH,
    localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic             clk,
    input  logic             rst,
    input  stk_op_e          op,
    output logic [IDX_W-1:0] wr_idx,
    output logic [IDX_W-1:0] rd_idx
);

    logic [IDX_W-1:0] idx_q;

    always_ff @(posedge clk) begin
        if (rst) idx_q <= '0;
        else     idx_q <= IDX_W'(ring_step(int'(idx_q), DEPTH, op));
    end

    assign wr_idx = idx_q;
    assign rd_idx = IDX_W'(ring_step(int'(idx_q), DEPTH, STK_POP));

    AST_RESET_IDX: assert property (@(posedge clk)
        rst |=> idx_q == '0); // R1
    AST_PUSH_ADVANCE: assert property (@(posedge clk) disable iff (rst)
        (op == STK_PUSH) |=> idx_q == (($past(idx_q) == IDX_W'(DEPTH - 1)) ? '0 : $past(idx_q) + 1'b1)); // R2
    AST_POP_RETREAT: assert property (@(posedge clk) disable iff (rst)
        (op == STK_POP) |=> idx_q == (($past(idx_q) == '0) ? IDX_W'(DEPTH - 1) : $past(idx_q) - 1'b1)); // R3
    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
        (op == STK_IDLE) |=> $stable(idx_q)); // R8

endmodule

// File: rtl/ret_stack_mem.sv
module ret_stack_mem
    import ret_stack_pkg::*;
#(
    parameter int DEPTH = STK_DEPTH,
    parameter int WIDTH = STK_WIDTH,
    localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic [WIDTH-1:0] wr_data,
    input  logic [IDX_W-1:0] rd_idx,
    output logic [WIDTH-1:0] rd_data
);

    logic [WIDTH-1:0] slot [DEPTH];

    // One register per slot; none is reset, so contents survive rst.
    for (genvar g = 0; g < DEPTH; g++) begin : g_slot
        always_ff @(posedge clk) begin
            if (wr_en && (wr_idx == IDX_W'(g))) slot[g] <= wr_data;
        end
    end

    assign rd_data = slot[rd_idx];

    AST_WRITE_LANDS: assert property (@(posedge clk) disable iff (rst)
        wr_en |=> slot[$past(wr_idx)] == $past(wr_data)); // R2

endmodule

// File: rtl/ret_stack.sv
module ret_stack
    import ret_stack_pkg::*;
#(
    parameter int DEPTH = STK_DEPTH,
    parameter int WIDTH = STK_WIDTH,
    localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             push,
    input  logic [WIDTH-1:0] push_addr,
    input  logic             pop,
    output logic [WIDTH-1:0] pop_addr
);

    stk_op_e          op;
    logic [IDX_W-1:0] wr_idx;
    logic [IDX_W-1:0] rd_idx;
    logic [WIDTH-1:0] rd_data;
    logic [WIDTH-1:0] out_q;

    ret_stack_ctrl u_ctrl (
        .clk  (clk),
        .rst  (rst),
        .push (push),
        .pop  (pop),
        .op   (op)
    );

    ret_stack_ptr #(.DEPTH(DEPTH)) u_ptr (
        .clk    (clk),
        .rst    (rst),
        .op     (op),
        .wr_idx (wr_idx),
        .rd_idx (rd_idx)
    );

    ret_stack_mem #(.DEPTH(DEPTH), .WIDTH(WIDTH)) u_mem (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (op == STK_PUSH),
        .wr_idx  (wr_idx),
        .wr_data (push_addr),
        .rd_idx  (rd_idx),
        .rd_data (rd_data)
    );

    always_ff @(posedge clk) begin
        if (rst)                out_q <= '0;
        else if (op == STK_POP) out_q <= rd_data;
    end

    assign pop_addr = out_q;

    AST_RESET_OUT: assert property (@(posedge clk)
        rst |=> pop_addr == '0); // R1
    AST_OUT_HOLD: assert property (@(posedge clk) disable iff (rst)
        !pop |=> $stable(pop_addr)); // R3
    AST_POP_TOP: assert property (@(posedge clk) disable iff (rst)
        pop |=> pop_addr == $past(rd_data)); // R3

endmodule

// File: tb/sim_ret_stack.sv
module sim_ret_stack;

    localparam int DEPTH = 8;
    localparam int WIDTH = 13;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             push = 1'b0;
    logic             pop = 1'b0;
    logic [WIDTH-1:0] push_addr = '0;
    logic [WIDTH-1:0] pop_addr;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    logic [WIDTH-1:0] mdl [DEPTH];
    int mptr = 0;

    always #5 clk = ~clk;

    ret_stack #(.DEPTH(DEPTH), .WIDTH(WIDTH)) u0 (
        .clk(clk), .rst(rst), .push(push), .push_addr(push_addr),
        .pop(pop), .pop_addr(pop_addr)
    );

    function automatic int wrap_inc(input int p);
        return (p == DEPTH - 1) ? 0 : p + 1;
    endfunction

    function automatic int wrap_dec(input int p);
        return (p == 0) ? DEPTH - 1 : p - 1;
    endfunction

    task automatic check(input string req, input logic [WIDTH-1:0] act, input logic [WIDTH-1:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic do_push(input logic [WIDTH-1:0] v);
        @(negedge clk);
        push = 1'b1; push_addr = v;
        @(posedge clk); #1;
        push = 1'b0;
        mdl[mptr] = v;
        mptr = wrap_inc(mptr);
    endtask

    task automatic do_pop(input string req);
        @(negedge clk);
        pop = 1'b1;
        @(posedge clk); #1;
        pop = 1'b0;
        mptr = wrap_dec(mptr);
        check(req, pop_addr, mdl[mptr]);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        @(posedge clk); #1;
        rst = 1'b0;
        mptr = 0;
    endtask

    initial begin
        logic [WIDTH-1:0] held;
        int r;
        void'($urandom(32'd20240611));
        repeat (2) @(posedge clk);
        #1;
        rst = 1'b0;
        check("R1 reset pop_addr", pop_addr, '0);

        // Fill every slot with known values.
        for (int i = 0; i < DEPTH; i++) do_push(WIDTH'(13'h100 + i));

        // R7 and R1: reset keeps the entries and zeroes the index.
        do_reset();
        check("R1 pop_addr after reset", pop_addr, '0);
        do_push(13'h1ABC);
        do_pop("R1 first push lands at slot 0");
        do_pop("R7 slot 7 survives reset");
        check("R7 explicit slot 7", pop_addr, 13'h107);

        // R2/R4: nested LIFO order.
        do_reset();
        do_push(13'h0011); do_push(13'h0022);
        do_pop("R4 inner return");
        check("R4 inner value", pop_addr, 13'h0022);
        do_push(13'h0033);
        do_pop("R2 push after pop reuses slot");
        do_pop("R4 outer return");
        check("R4 outer value", pop_addr, 13'h0011);

        // R5: nine pushes wrap over the first.
        do_reset();
        for (int i = 1; i <= 9; i++) do_push(WIDTH'(13'h0A00 + i));
        for (int i = 9; i >= 2; i--) begin
            do_pop("R5 unwind after wrap");
            check("R5 expected push order", pop_addr, WIDTH'(13'h0A00 + i));
        end
        do_pop("R5 ninth pop sees push nine again");
        check("R5 push nine value", pop_addr, 13'h0A09);

        // R6: underflow returns stale data.
        do_pop("R6 stale after underflow");

        // R8: idle cycles keep output and later pops.
        held = pop_addr;
        repeat (5) @(posedge clk);
        #1;
        check("R8 idle hold", pop_addr, held);
        do_pop("R8 pop after idle");

        // R3/R4/R6/R9: random mix, one operation per cycle.
        for (int n = 0; n < 3000; n++) begin
            r = int'($urandom_range(0, 9));
            if (r < 5) do_push(WIDTH'($urandom()));
            else if (r < 9) do_pop("R3 random pop");
            else begin
                held = pop_addr;
                @(posedge clk); #1;
                check("R8 random idle", pop_addr, held);
            end
        end

        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #2000000;
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule